// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the bus-facing front end of a small monitoring device. It sits on a two-wire serial bus (SMBus / I2C style) as a slave and gives the bus master access to a bank of eight-bit registers. It does this through a single internal pointer. The first byte of every write transfer loads the pointer. An optional second byte is written to the register the pointer selects. A read transfer returns the register the pointer currently selects, and needs no pointer write ahead of it. Read and write use separate register addresses for the same physical register. The register storage itself lives outside the block. The block emits one-cycle write strobes with data, and receives read data for the register index it selects.

The seven-bit bus address is chosen by two three-level strap inputs. These are captured only while reset is asserted. The block also answers the SMBus alert-response address. If its alert is pending, it acknowledges, returns its own address and pulses an alert-serviced strobe. If another responder with a lower address wins the bus, it backs off. The bus lines are brought through synchronizers, and the block runs on a system clock at least ten times the serial clock rate. It never stretches the clock.

Top module: `smb_ptr_slave`

## Requirements
- R1: The device address is computed from the straps while reset is low. Each strap is encoded 00 = tied low, 01 = open, 10 = tied high, and 11 counts as open. Each `strap_lo_i` value picks a base: low gives 0x18, open gives 0x29, high gives 0x4C. The `strap_hi_i` value adds 0, 1 or 2 for low, open or high. Strap changes after reset have no effect.
- R2: The slave drives SDA low during the ninth clock of an address byte whose upper seven bits equal the device address. For any other address, except R9, it does not acknowledge and stays off the bus until the next START.
- R3: The first byte after a write address (R/W bit 0) is acknowledged and loads the pointer. A transfer carrying only this byte writes nothing.
- R4: The second write byte is acknowledged and raises a single-cycle pulse on bit k of `wr_en_o` when the pointer equals 0x09+k (k = 0..5: configuration, rate, local high, local low, remote high, remote low). The byte appears on `wr_data_o` in the same cycle and stays there on the next cycle. The same byte sent to any other pointer value, and any byte after the second, is acknowledged and discarded with no strobe.
- R5: A second write byte sent with pointer 0x0F produces a single-cycle `oneshot_o` pulse, and its value is discarded. At most one of the strobe outputs is high in any cycle.
- R6: A read returns one byte chosen by the pointer, which the block drives on `rd_idx_o[3:0]`. Pointers 0x00..0x08 return `rd_value_i`. 0xFE returns 0x41, 0xFF returns 0x31, and every other value returns 0x00. The pointer persists across transfers. If the master ACKs a read byte, the same register is sent again.
- R7: The slave only begins pulling SDA low while SCL is low. It releases SDA for the master's acknowledge bit, and after a master NACK it stays released until the next START. After reset it does not drive.
- R8: Each read byte sent from pointer 0x02 (status) is followed by a single-cycle `status_rd_o` pulse.
- R9: A read addressed to 0x0C (alert response) is acknowledged only while `alert_pend_i` is high. The slave then sends its device address followed by a 0 bit and pulses `alert_done_o` after the byte.
- R10: Suppose the slave sends a 1 on a read byte and samples the line low. It releases SDA for the rest of the byte, leaves the other bits to the other driver, and gives no `alert_done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_lo_i | input | 2 | Three-level strap selecting the address base |
| strap_hi_i | input | 2 | Three-level strap selecting the address offset |
| alert_pend_i | input | 1 | Alert from this device is waiting for service |
| rd_value_i | input | 8 | Register read data for the index on `rd_idx_o` |
| sda_low_o | output | 1 | Pull SDA low when high (open-drain enable) |
| rd_idx_o | output | 4 | Low four bits of the pointer, selecting read data |
| wr_en_o | output | 6 | One-hot write strobes for the six writable registers |
| wr_data_o | output | 8 | Data for the write strobe |
| oneshot_o | output | 1 | Single-conversion request pulse |
| status_rd_o | output | 1 | Status register has been read |
| alert_done_o | output | 1 | Alert response has been delivered |

## Verification
A wrong pointer shows at the next read as a byte from the wrong register or a constant where a register should be. A wrong pointer also sends a write strobe to the wrong bit, and the per-clock strobe monitor reports that in the cycle it fires. A wrong bit count or sequencer state first shows as a missing or early acknowledge in the ninth clock of the same byte. It can also show as SDA pulled outside the windows where the slave may drive, and the monitor catches that within a few system clocks of the serial edge. Strap capture and arbitration faults show as a wrong acknowledge, or a wrong byte value seen by the master, on the first transfer that uses them.

// File: rtl/smb_ptr_pkg.sv
// Package: shared constants, sequencer state type and strap address decode
// for the pointer-addressed two-wire register slave.
package smb_ptr_pkg;

    localparam int DEV_ADDR_W = 7;
    localparam int BYTE_W     = 8;

    // Strap encodings: low, open, high (11 is treated as open)
    localparam logic [1:0] STRAP_LOW  = 2'b00;
    localparam logic [1:0] STRAP_HIGH = 2'b10;

    typedef enum logic [2:0] {
        B_IDLE,
        B_ADDR,
        B_ADDR_ACK,
        B_RX,
        B_RX_ACK,
        B_TX,
        B_TX_ACK,
        B_WAIT
    } bus_state_t;

    // Device address from the two three-level straps
    function automatic logic [DEV_ADDR_W-1:0] strap_address(input logic [1:0] sel_base,
                                                            input logic [1:0] sel_step);
        logic [DEV_ADDR_W-1:0] base;
        logic [DEV_ADDR_W-1:0] step;
        case (sel_base)
            STRAP_LOW:  base = 7'h18;
            STRAP_HIGH: base = 7'h4C;
            default:    base = 7'h29;
        endcase
        case (sel_step)
            STRAP_LOW:  step = 7'd0;
            STRAP_HIGH: step = 7'd2;
            default:    step = 7'd1;
        endcase
        return base + step;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Brings one asynchronous bus line into the clock domain through a chain of
// STAGES flops and reports its level and one-cycle rise/fall pulses.
// Assumes the line idles high; reset fills the chain with ones.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Purpose: shift the raw line through the synchronizer and keep last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;
    assign fall_o  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/smb_addr_strap.sv
// Module: smb_addr_strap
// Holds the seven-bit device address. The straps are only looked at while
// reset is asserted; later changes on them are ignored.
module smb_addr_strap
    import smb_ptr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            strap_lo_i,
    input  logic [1:0]            strap_hi_i,
    output logic [DEV_ADDR_W-1:0] dev_addr_o
);

    // Purpose: capture the decoded strap address during reset only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_addr_o <= strap_address(strap_lo_i, strap_hi_i);
        end
    end

endmodule

// File: rtl/smb_reg_map.sv
// Module: smb_reg_map
// Decodes the pointer into read data selection and write strobes.
// Read addresses 0..RD_LAST come from outside storage; two identity bytes are
// constants; other read addresses give zero. Write addresses WR_BASE..WR_BASE+
// NUM_WR-1 strobe one-hot, ONESHOT_ADDR strobes the one-shot.
module smb_reg_map #(
    parameter int          RD_LAST      = 8,
    parameter int          WR_BASE      = 9,
    parameter int          NUM_WR       = 6,
    parameter logic [7:0]  ONESHOT_ADDR = 8'h0F,
    parameter logic [7:0]  STATUS_ADDR  = 8'h02,
    parameter logic [7:0]  ID_ADDR      = 8'hFE,
    parameter logic [7:0]  REV_ADDR     = 8'hFF,
    parameter logic [7:0]  ID_VALUE     = 8'h41,
    parameter logic [7:0]  REV_VALUE    = 8'h31
) (
    input  logic [7:0]        ptr_i,
    input  logic [7:0]        rd_value_i,
    input  logic              wr_fire_i,
    output logic [3:0]        rd_idx_o,
    output logic [7:0]        tx_byte_o,
    output logic [NUM_WR-1:0] wr_en_o,
    output logic              oneshot_o,
    output logic              is_status_o
);

    localparam logic [7:0] RD_LAST_B = 8'(RD_LAST);

    assign rd_idx_o    = ptr_i[3:0];
    assign is_status_o = (ptr_i == STATUS_ADDR);
    assign oneshot_o   = wr_fire_i && (ptr_i == ONESHOT_ADDR);

    // Purpose: choose the byte to send for the current pointer
    always_comb begin
        if (ptr_i <= RD_LAST_B) begin
            tx_byte_o = rd_value_i;
        end else if (ptr_i == ID_ADDR) begin
            tx_byte_o = ID_VALUE;
        end else if (ptr_i == REV_ADDR) begin
            tx_byte_o = REV_VALUE;
        end else begin
            tx_byte_o = 8'h00;
        end
    end

    for (genvar k = 0; k < NUM_WR; k++) begin : g_wr
        assign wr_en_o[k] = wr_fire_i && (ptr_i == 8'(WR_BASE + k));
    end

endmodule

// File: rtl/smb_bus_fsm.sv
// Module: smb_bus_fsm
// Bit/byte sequencer for the slave. Works on synchronized levels and edge
// pulses; shifts on SCL rise, changes SDA on SCL fall. Handles address match,
// alert-response, pointer load, write fire, read transmit with arbitration.
// Assumes SCL low and high phases last several system clocks.
module smb_bus_fsm
    import smb_ptr_pkg::*;
#(
    parameter logic [DEV_ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sda_lvl_i,
    input  logic                  scl_rise_i,
    input  logic                  scl_fall_i,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic [DEV_ADDR_W-1:0] dev_addr_i,
    input  logic                  alert_pend_i,
    input  logic [BYTE_W-1:0]     tx_reg_byte_i,
    input  logic                  is_status_i,
    output logic                  sda_low_o,
    output logic [BYTE_W-1:0]     ptr_o,
    output logic [BYTE_W-1:0]     rx_byte_o,
    output logic                  wr_fire_o,
    output logic                  status_stb_o,
    output logic                  alert_stb_o
);

    localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

    bus_state_t        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              ara;
    logic [1:0]        byte_no;
    logic              host_ack;
    logic [BYTE_W-1:0] next_tx;

    // Purpose: byte to load for transmit (own address in alert response)
    always_comb begin
        next_tx = ara ? {dev_addr_i, 1'b0} : tx_reg_byte_i;
    end

    // Purpose: advance the bus sequencer on synchronized edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= B_IDLE;
            bit_cnt      <= '0;
            shreg        <= '0;
            rw           <= 1'b0;
            ara          <= 1'b0;
            byte_no      <= '0;
            host_ack     <= 1'b0;
            sda_low_o    <= 1'b0;
            ptr_o        <= '0;
            rx_byte_o    <= '0;
            wr_fire_o    <= 1'b0;
            status_stb_o <= 1'b0;
            alert_stb_o  <= 1'b0;
        end else begin
            wr_fire_o    <= 1'b0;
            status_stb_o <= 1'b0;
            alert_stb_o  <= 1'b0;
            if (start_i) begin
                state     <= B_ADDR;
                bit_cnt   <= '0;
                sda_low_o <= 1'b0;
            end else if (stop_i) begin
                state     <= B_IDLE;
                sda_low_o <= 1'b0;
            end else begin
                case (state)
                    B_ADDR: begin
                        if (scl_rise_i) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl_i};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall_i && bit_cnt == BITS_PER_BYTE) begin
                            byte_no <= '0;
                            if (shreg[BYTE_W-1:1] == dev_addr_i) begin
                                state     <= B_ADDR_ACK;
                                sda_low_o <= 1'b1;
                                rw        <= shreg[0];
                                ara       <= 1'b0;
                            end else if (shreg[BYTE_W-1:1] == ARA_ADDR && shreg[0] && alert_pend_i) begin
                                state     <= B_ADDR_ACK;
                                sda_low_o <= 1'b1;
                                rw        <= 1'b1;
                                ara       <= 1'b1;
                            end else begin
                                state <= B_WAIT;
                            end
                        end
                    end
                    B_ADDR_ACK: begin
                        if (scl_fall_i) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                state     <= B_TX;
                                shreg     <= next_tx;
                                sda_low_o <= ~next_tx[BYTE_W-1];
                            end else begin
                                state     <= B_RX;
                                sda_low_o <= 1'b0;
                            end
                        end
                    end
                    B_RX: begin
                        if (scl_rise_i) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl_i};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall_i && bit_cnt == BITS_PER_BYTE) begin
                            state     <= B_RX_ACK;
                            sda_low_o <= 1'b1;
                            if (byte_no == 2'd0) begin
                                ptr_o <= shreg;
                            end else if (byte_no == 2'd1) begin
                                rx_byte_o <= shreg;
                                wr_fire_o <= 1'b1;
                            end
                            if (byte_no != 2'd2) begin
                                byte_no <= byte_no + 2'd1;
                            end
                        end
                    end
                    B_RX_ACK: begin
                        if (scl_fall_i) begin
                            state     <= B_RX;
                            bit_cnt   <= '0;
                            sda_low_o <= 1'b0;
                        end
                    end
                    B_TX: begin
                        if (scl_rise_i) begin
                            bit_cnt <= bit_cnt + 4'd1;
                            if (shreg[BYTE_W-1] && !sda_lvl_i) begin
                                state     <= B_WAIT;
                                sda_low_o <= 1'b0;
                            end
                        end else if (scl_fall_i) begin
                            if (bit_cnt == BITS_PER_BYTE) begin
                                state     <= B_TX_ACK;
                                sda_low_o <= 1'b0;
                            end else begin
                                shreg     <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_low_o <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    B_TX_ACK: begin
                        if (scl_rise_i) begin
                            host_ack <= ~sda_lvl_i;
                        end else if (scl_fall_i) begin
                            if (ara) begin
                                alert_stb_o <= 1'b1;
                            end else if (is_status_i) begin
                                status_stb_o <= 1'b1;
                            end
                            if (host_ack) begin
                                state     <= B_TX;
                                bit_cnt   <= '0;
                                shreg     <= next_tx;
                                sda_low_o <= ~next_tx[BYTE_W-1];
                            end else begin
                                state <= B_WAIT;
                            end
                        end
                    end
                    default: begin
                        sda_low_o <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_ptr_slave.sv
// Module: smb_ptr_slave (top)
// Two-wire bus slave giving pointer-addressed access to an external register
// bank, with strap-selected address and alert-response support.
// Assumes clk runs at least 10x the serial clock; no clock stretching.
module smb_ptr_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_WR      = 6,
    parameter logic [6:0] ARA_ADDR    = 7'h0C,
    parameter logic [7:0] ID_VALUE    = 8'h41,
    parameter logic [7:0] REV_VALUE   = 8'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_lo_i,
    input  logic [1:0]        strap_hi_i,
    input  logic              alert_pend_i,
    input  logic [7:0]        rd_value_i,
    output logic              sda_low_o,
    output logic [3:0]        rd_idx_o,
    output logic [NUM_WR-1:0] wr_en_o,
    output logic [7:0]        wr_data_o,
    output logic              oneshot_o,
    output logic              status_rd_o,
    output logic              alert_done_o
);

    import smb_ptr_pkg::*;

    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;
    localparam int NUM_LN = 2;

    logic [NUM_LN-1:0]     raw_ln;
    logic [NUM_LN-1:0]     lvl_ln;
    logic [NUM_LN-1:0]     rise_ln;
    logic [NUM_LN-1:0]     fall_ln;
    logic                  start_det;
    logic                  stop_det;
    logic [DEV_ADDR_W-1:0] dev_addr;
    logic [BYTE_W-1:0]     ptr;
    logic [BYTE_W-1:0]     tx_byte;
    logic                  wr_fire;
    logic                  is_status;

    assign raw_ln[LN_SCL] = scl_i;
    assign raw_ln[LN_SDA] = sda_i;

    for (genvar g = 0; g < NUM_LN; g++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_ln[g]),
            .level_o (lvl_ln[g]),
            .rise_o  (rise_ln[g]),
            .fall_o  (fall_ln[g])
        );
    end

    // START: data falls with clock high; STOP: data rises with clock high
    assign start_det = fall_ln[LN_SDA] & lvl_ln[LN_SCL];
    assign stop_det  = rise_ln[LN_SDA] & lvl_ln[LN_SCL];

    smb_addr_strap u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_lo_i (strap_lo_i),
        .strap_hi_i (strap_hi_i),
        .dev_addr_o (dev_addr)
    );

    smb_bus_fsm #(.ARA_ADDR(ARA_ADDR)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_lvl_i     (lvl_ln[LN_SDA]),
        .scl_rise_i    (rise_ln[LN_SCL]),
        .scl_fall_i    (fall_ln[LN_SCL]),
        .start_i       (start_det),
        .stop_i        (stop_det),
        .dev_addr_i    (dev_addr),
        .alert_pend_i  (alert_pend_i),
        .tx_reg_byte_i (tx_byte),
        .is_status_i   (is_status),
        .sda_low_o     (sda_low_o),
        .ptr_o         (ptr),
        .rx_byte_o     (wr_data_o),
        .wr_fire_o     (wr_fire),
        .status_stb_o  (status_rd_o),
        .alert_stb_o   (alert_done_o)
    );

    smb_reg_map #(
        .NUM_WR    (NUM_WR),
        .ID_VALUE  (ID_VALUE),
        .REV_VALUE (REV_VALUE)
    ) u_map (
        .ptr_i       (ptr),
        .rd_value_i  (rd_value_i),
        .wr_fire_i   (wr_fire),
        .rd_idx_o    (rd_idx_o),
        .tx_byte_o   (tx_byte),
        .wr_en_o     (wr_en_o),
        .oneshot_o   (oneshot_o),
        .is_status_o (is_status)
    );

endmodule

// File: rtl/smb_ptr_slave_chk.sv
// Module: smb_ptr_slave_chk
// Port-level protocol checks for smb_ptr_slave, attached with bind.
module smb_ptr_slave_chk #(
    parameter int NUM_WR = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_low_o,
    input logic [NUM_WR-1:0] wr_en_o,
    input logic [7:0]        wr_data_o,
    input logic              oneshot_o,
    input logic              status_rd_o,
    input logic              alert_done_o
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_o, oneshot_o, status_rd_o, alert_done_o})); // R5

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en_o) |=> (wr_en_o == '0)); // R4

    AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en_o) |=> $stable(wr_data_o)); // R4

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> !scl_i); // R7

    AST_ONESHOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_o |=> !oneshot_o); // R5

endmodule

bind smb_ptr_slave smb_ptr_slave_chk #(.NUM_WR(NUM_WR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_low_o    (sda_low_o),
    .wr_en_o      (wr_en_o),
    .wr_data_o    (wr_data_o),
    .oneshot_o    (oneshot_o),
    .status_rd_o  (status_rd_o),
    .alert_done_o (alert_done_o)
);

// File: tb/test_smb_ptr_slave.sv
// Bench: drives a behavioural bus master, a competing responder and a stand-in
// register store; a per-clock monitor compares strobes to an expected queue.
module test_smb_ptr_slave;

    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m, other_low;
    logic [1:0] s_lo, s_hi;
    logic       alert_pend;
    logic       sda_line;
    logic       sda_low;
    logic [3:0] rd_idx;
    logic [5:0] wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_value;
    logic       oneshot, status_rd, alert_done;

    int  checks   = 0;
    int  failures = 0;
    int  exp_q[$];
    logic slave_turn = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_low & ~other_low;
    assign rd_value = {4'hA, rd_idx};

    smb_ptr_slave i_smb_ptr_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .strap_lo_i   (s_lo),
        .strap_hi_i   (s_hi),
        .alert_pend_i (alert_pend),
        .rd_value_i   (rd_value),
        .sda_low_o    (sda_low),
        .rd_idx_o     (rd_idx),
        .wr_en_o      (wr_en),
        .wr_data_o    (wr_data),
        .oneshot_o    (oneshot),
        .status_rd_o  (status_rd),
        .alert_done_o (alert_done)
    );

    function automatic int ev(input int kind, input logic [7:0] d);
        return kind * 256 + int'(d);
    endfunction

    function automatic logic [6:0] model_addr(input logic [1:0] lo, input logic [1:0] hi);
        int b, o;
        b = (lo == 2'b00) ? 8'h18 : (lo == 2'b10) ? 8'h4C : 8'h29;
        o = (hi == 2'b00) ? 0 : (hi == 2'b10) ? 2 : 1;
        return 7'(b + o);
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] p);
        if (p <= 8'h08) return 8'hA0 | p;
        if (p == 8'hFE) return 8'h41;
        if (p == 8'hFF) return 8'h31;
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock monitor: strobes against the expected queue, SDA drive window
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int n;
            int obs;
            n = $countones({wr_en, oneshot, status_rd, alert_done});
            obs = 0;
            for (int k = 0; k < 6; k++) if (wr_en[k]) obs = ev(k + 1, wr_data);
            if (oneshot)    obs = ev(7, 8'h00);
            if (status_rd)  obs = ev(8, 8'h00);
            if (alert_done) obs = ev(9, 8'h00);
            if (n > 1) begin
                check(1'b0, "R5", "several strobes in one cycle", n, 1);
            end else if (n == 1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected strobe", obs, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(obs == e, "R4", "strobe kind/data", obs, e);
                end
            end
            if (sda_low && !slave_turn) begin
                check(1'b0, "R7", "slave drove SDA outside its turn", 1, 0);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic smp);
        wait_cyc(2);
        sda_m = b;
        wait_cyc(HALF - 2);
        scl_m = 1'b1;
        wait_cyc(HALF / 2);
        smp = sda_line;
        wait_cyc(HALF / 2);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_cyc(2);
        scl_m = 1'b1;
        wait_cyc(HALF);
        sda_m = 1'b0;
        wait_cyc(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_cyc(8);
        slave_turn = 1'b0;
        wait_cyc(2);
        sda_m = 1'b0;
        wait_cyc(HALF);
        scl_m = 1'b1;
        wait_cyc(HALF);
        sda_m = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        wait_cyc(8);
        slave_turn = 1'b0;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        slave_turn = 1'b1;
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic mnack, input logic [7:0] comp, input bit use_comp,
                             output logic [7:0] b);
        logic s;
        slave_turn = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            other_low = use_comp & ~comp[i];
            clk_bit(1'b1, s);
            b[i] = s;
        end
        other_low = 1'b0;
        wait_cyc(8);
        slave_turn = 1'b0;
        clk_bit(mnack, s);
        slave_turn = ~mnack;
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] p, input int nd,
                             input logic [7:0] d0, input logic [7:0] d1,
                             input logic exp_ack, input string req);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check(ack == exp_ack, req, "address acknowledge", ack, exp_ack);
        if (ack) begin
            send_byte(p, ack);
            check(ack == 1'b1, "R3", "pointer byte acknowledge", ack, 1);
            if (nd >= 1) begin
                send_byte(d0, ack);
                check(ack == 1'b1, "R4", "data byte acknowledge", ack, 1);
            end
            if (nd >= 2) begin
                send_byte(d1, ack);
                check(ack == 1'b1, "R4", "extra byte acknowledge", ack, 1);
            end
        end
        bus_stop();
        wait_cyc(10);
        check(exp_q.size() == 0, req, "expected strobes outstanding", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic read_txn(input logic [6:0] a, input logic exp_ack, input int nbytes,
                            input logic [7:0] exp_b, input logic [7:0] comp, input bit use_comp,
                            input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({a, 1'b1}, ack);
        check(ack == exp_ack, req, "read address acknowledge", ack, exp_ack);
        if (ack) begin
            for (int k = 0; k < nbytes; k++) begin
                recv_byte((k == nbytes - 1), comp, use_comp, b);
                check(b == exp_b, req, "read byte", b, exp_b);
            end
        end
        bus_stop();
        wait_cyc(10);
        check(exp_q.size() == 0, req, "expected strobes outstanding", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic do_reset(input logic [1:0] lo, input logic [1:0] hi);
        rst_n = 1'b0;
        s_lo = lo;
        s_hi = hi;
        scl_m = 1'b1;
        sda_m = 1'b1;
        other_low = 1'b0;
        slave_turn = 1'b0;
        exp_q.delete();
        wait_cyc(6);
        rst_n = 1'b1;
        wait_cyc(6);
        check(sda_low == 1'b0, "R7", "reset SDA release", sda_low, 0);
        check({wr_en, oneshot, status_rd, alert_done} == '0, "R4", "reset strobes",
              {wr_en, oneshot, status_rd, alert_done}, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        logic [6:0] dev;
        alert_pend = 1'b0;
        do_reset(2'b01, 2'b00);
        dev = model_addr(2'b01, 2'b00);

        // R2 R3: pointer-only write, then reads from that pointer (R6)
        write_reg(dev, 8'h05, 0, 8'h00, 8'h00, 1'b1, "R2");
        read_txn(dev, 1'b1, 1, model_read(8'h05), 8'h00, 1'b0, "R6");
        read_txn(dev, 1'b1, 1, model_read(8'h05), 8'h00, 1'b0, "R6");

        // R4: every writable register strobes its own bit
        for (int k = 0; k < 6; k++) begin
            exp_q.push_back(ev(k + 1, 8'h10 + 8'(k)));
            write_reg(dev, 8'h09 + 8'(k), 1, 8'h10 + 8'(k), 8'h00, 1'b1, "R4");
        end
        // R6: pointer left at a write address reads as zero
        read_txn(dev, 1'b1, 1, 8'h00, 8'h00, 1'b0, "R6");

        // R5: one-shot
        exp_q.push_back(ev(7, 8'h00));
        write_reg(dev, 8'h0F, 1, 8'h55, 8'h00, 1'b1, "R5");

        // R4: data to a read address is discarded; pointer still moves (R3)
        write_reg(dev, 8'h03, 1, 8'h12, 8'h00, 1'b1, "R4");
        read_txn(dev, 1'b1, 1, model_read(8'h03), 8'h00, 1'b0, "R3");

        // R4: third byte discarded
        exp_q.push_back(ev(1, 8'h80));
        write_reg(dev, 8'h09, 2, 8'h80, 8'h44, 1'b1, "R4");

        // R6: identity, revision, reserved
        write_reg(dev, 8'hFE, 0, 8'h00, 8'h00, 1'b1, "R6");
        read_txn(dev, 1'b1, 1, 8'h41, 8'h00, 1'b0, "R6");
        write_reg(dev, 8'hFF, 0, 8'h00, 8'h00, 1'b1, "R6");
        read_txn(dev, 1'b1, 1, 8'h31, 8'h00, 1'b0, "R6");
        write_reg(dev, 8'h20, 0, 8'h00, 8'h00, 1'b1, "R6");
        read_txn(dev, 1'b1, 1, 8'h00, 8'h00, 1'b0, "R6");

        // R8: status read, master ACKs first byte so it repeats (R6)
        write_reg(dev, 8'h02, 0, 8'h00, 8'h00, 1'b1, "R8");
        exp_q.push_back(ev(8, 8'h00));
        exp_q.push_back(ev(8, 8'h00));
        read_txn(dev, 1'b1, 2, model_read(8'h02), 8'h00, 1'b0, "R8");

        // R2: another address is not acknowledged
        write_reg(dev + 7'd1, 8'h00, 0, 8'h00, 8'h00, 1'b0, "R2");

        // R9: alert response only while pending
        read_txn(7'h0C, 1'b0, 1, 8'h00, 8'h00, 1'b0, "R9");
        alert_pend = 1'b1;
        exp_q.push_back(ev(9, 8'h00));
        read_txn(7'h0C, 1'b1, 1, {dev, 1'b0}, 8'h00, 1'b0, "R9");

        // R10: lower-address responder wins; slave backs off, no alert strobe
        read_txn(7'h0C, 1'b1, 1, 8'h30, 8'h30, 1'b1, "R10");
        alert_pend = 1'b0;

        // R1: strap change after reset has no effect
        s_lo = 2'b10;
        s_hi = 2'b10;
        wait_cyc(10);
        write_reg(dev, 8'h00, 0, 8'h00, 8'h00, 1'b1, "R1");
        write_reg(model_addr(2'b10, 2'b10), 8'h00, 0, 8'h00, 8'h00, 1'b0, "R1");

        // R1: other strap settings take effect at reset
        do_reset(2'b10, 2'b10);
        write_reg(model_addr(2'b10, 2'b10), 8'h00, 0, 8'h00, 8'h00, 1'b1, "R1");
        write_reg(dev, 8'h00, 0, 8'h00, 8'h00, 1'b0, "R1");
        do_reset(2'b00, 2'b00);
        write_reg(model_addr(2'b00, 2'b00), 8'h00, 0, 8'h00, 8'h00, 1'b1, "R1");
        do_reset(2'b11, 2'b01);
        write_reg(model_addr(2'b01, 2'b01), 8'h00, 0, 8'h00, 8'h00, 1'b1, "R1");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule